// File: doc/BRIEF.md
# Dual-Channel Output-Compare Timer

This block is a 16-bit up-counter shared by two output-compare channels, A and B. Each channel holds its own compare value and drives one output pin. When the running count equals a channel's compare value, that channel fires one match event. The event can drive its pin low, drive it high, toggle it, or leave it alone. A small prescaler turns the system clock into a count-enable tick at a rate of clk/1, clk/2, clk/4 or clk/8. The counter moves only on that tick, and only while the run bit is set.

A count state lasts from one tick to the next. The match event for a state is raised in the last system-clock cycle of that state, which is the cycle carrying the tick. The output pin, the one-cycle hit output and the sticky flag therefore all change on the same edge at which the counter steps to the next value. At most one event is raised per count state. Writing a compare value disarms that channel until the next tick, so a value written equal to the current count does not fire in the state where it was written.

Software programs the block through a plain write port. Every write is accepted in the cycle it is presented; there is no valid/ready handshake and no back-pressure. The register addresses are 0 for control, 1 for channel configuration, 2 for compare A, 3 for compare B and 4 for status. Writes to addresses 5 to 7 are ignored. Status and count leave the block on dedicated output pins.

Top module: `oc_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the counter, the run bit, the divider select, both compare values, both channel configurations, both output pins, both hit outputs and both flags to 0.
- R2: Control register (address 0) bit 0 is the run bit. While it is 0, `count_o` holds its value. While it is 1, the counter adds 1 on every count-enable tick.
- R3: Control bits [2:1] select the tick rate: 0 gives clk/1, 1 gives clk/2, 2 gives clk/4 and 3 gives clk/8. A control write restarts the divider phase. With divide-by-N, the first step after that write appears exactly N cycles later.
- R4: The counter wraps from 0xFFFF to 0x0000. A compare value of 0x0000 fires only when state 0x0000 ends, never at the wrap itself.
- R5: A channel whose compare value equals the count fires in the last cycle of that count state. On the edge where the count steps, its hit output goes high for exactly one cycle and its output pin applies the action.
- R6: A channel fires at most once per count state. Its hit output is never high in two consecutive cycles.
- R7: Configuration register (address 1) holds two action fields: bits [1:0] for A and bits [4:3] for B. The codes are 0 = keep, 1 = drive low, 2 = drive high and 3 = toggle.
- R8: Configuration bit 2 (A) and bit 5 (B) give each pin's level before its first match. A configuration write loads those levels into both pins on its own edge. This load takes priority over a match on the same edge, and otherwise the pins change only on a match.
- R9: Compare writes (address 2 for A, 3 for B) take effect at once. They disarm that channel until the next tick, so a value equal to the current count does not fire in the current state.
- R10: Each channel has a sticky flag set by its match. Writing 1 to status bit 0 (A) or bit 1 (B) at address 4 clears that flag. A match on the same edge takes priority over the clear.
- R11: The two channels are independent. A match, compare write or flag clear on one channel never changes the other channel's pin, hit output or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, accepted in the same cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| pin_a | output | 1 | Compare output pin of channel A |
| pin_b | output | 1 | Compare output pin of channel B |
| hit_a | output | 1 | One-cycle match indication of channel A |
| hit_b | output | 1 | One-cycle match indication of channel B |
| flag_a | output | 1 | Sticky match flag of channel A |
| flag_b | output | 1 | Sticky match flag of channel B |

## Verification
On every cycle, the assertions check the following:
- The counter holds when there is no tick and steps by exactly one, wrapping, on a tick.
- A tick at a divider setting other than 1 is followed by a cycle without one.
- A hit is never repeated in the next cycle.
- A pin moves only on a match or a configuration load.
- A match always leaves its flag set, and a compare write always leaves the channel unable to fire in the following cycle.

Some behaviour needs the bench's scenarios to show it:
- the exact cycle on which a match lands relative to the count step;
- the N-cycle distance after a control write;
- the suppression of a compare value written equal to the current count;
- the wrap with compare values 0xFFFF and 0x0000;
- the action codes and configuration priorities.

The bench compares every output on every cycle against a model built from the requirements.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } oc_act_e;

  typedef enum logic [2:0] {
    ADDR_CTRL  = 3'd0,
    ADDR_CHCFG = 3'd1,
    ADDR_CMPA  = 3'd2,
    ADDR_CMPB  = 3'd3,
    ADDR_STAT  = 3'd4
  } oc_addr_e;

  // bits of one channel's slice in the configuration register
  localparam int CFG_SLICE_W = 3;

  typedef struct packed {
    logic    init;
    oc_act_e act;
  } oc_chcfg_t;

endpackage

// File: rtl/oc_regs.sv
module oc_regs
  import oc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CH   = 2,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic                        run_o,
  output logic [SEL_W-1:0]            sel_o,
  output logic                        ctrl_wr_o,
  output oc_chcfg_t [N_CH-1:0]        cfg_o,
  output logic                        cfg_wr_o,
  output logic [N_CH-1:0]             init_lvl_o,
  output logic [N_CH-1:0][CNT_W-1:0]  cmp_o,
  output logic [N_CH-1:0]             cmp_wr_o,
  output logic [N_CH-1:0]             stat_clr_o
);

  logic ctrl_sel, cfg_sel, stat_sel;

  assign ctrl_sel  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign cfg_sel   = wr_en && (wr_addr == ADDR_W'(ADDR_CHCFG));
  assign stat_sel  = wr_en && (wr_addr == ADDR_W'(ADDR_STAT));
  assign ctrl_wr_o = ctrl_sel;
  assign cfg_wr_o  = cfg_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o <= 1'b0;
      sel_o <= '0;
    end else if (ctrl_sel) begin
      run_o <= wr_data[0];
      sel_o <= wr_data[SEL_W:1];
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int BASE = ch * CFG_SLICE_W;
    logic hit_sel;

    assign hit_sel        = wr_en && (wr_addr == ADDR_W'(ADDR_CMPA) + ADDR_W'(ch));
    assign cmp_wr_o[ch]   = hit_sel;
    assign init_lvl_o[ch] = wr_data[BASE + 2];
    assign stat_clr_o[ch] = stat_sel && wr_data[ch];

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[ch] <= '{init: 1'b0, act: ACT_KEEP};
      end else if (cfg_sel) begin
        cfg_o[ch] <= '{init: wr_data[BASE + 2], act: oc_act_e'(wr_data[BASE +: 2])};
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_o[ch] <= '0;
      end else if (hit_sel) begin
        cmp_o[ch] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/oc_prescaler.sv
module oc_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             tick_o
);

  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(sel));
    end
  end

  assign tick_o = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R3: any divider above 1 leaves a gap after every tick
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick_o && sel != '0 && !restart) |=> !tick_o);

endmodule

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (tick) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_o));

  a_r4_step_wrap: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt_o == $past(cnt_o) + 1'b1);

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cmp_wr,
  input  oc_chcfg_t        cfg,
  input  logic             cfg_load,
  input  logic             load_lvl,
  input  logic             stat_clr,
  output logic             pin_o,
  output logic             hit_o,
  output logic             flag_o
);

  logic armed_q;
  logic hit_ev;
  logic pin_nxt;

  assign hit_ev = tick && armed_q && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
    end else if (cmp_wr) begin
      armed_q <= 1'b0;
    end else if (tick) begin
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    pin_nxt = pin_o;
    if (cfg_load) begin
      pin_nxt = load_lvl;
    end else if (hit_ev) begin
      unique case (cfg.act)
        ACT_LOW:    pin_nxt = 1'b0;
        ACT_HIGH:   pin_nxt = 1'b1;
        ACT_TOGGLE: pin_nxt = ~pin_o;
        default:    pin_nxt = pin_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o  <= 1'b0;
      hit_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      pin_o <= pin_nxt;
      hit_o <= hit_ev;
      if (hit_ev) begin
        flag_o <= 1'b1;
      end else if (stat_clr) begin
        flag_o <= 1'b0;
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);

  a_r8_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    (!hit_ev && !cfg_load) |=> $stable(pin_o));

  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    hit_ev |=> flag_o);

  a_r9_write_disarms: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> !hit_ev);

endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import oc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              pin_a,
  output logic              pin_b,
  output logic              hit_a,
  output logic              hit_b,
  output logic              flag_a,
  output logic              flag_b
);

  localparam int N_CH = 2;

  logic                       run, ctrl_wr, cfg_wr, tick;
  logic [SEL_W-1:0]           sel;
  oc_chcfg_t [N_CH-1:0]       cfg;
  logic [N_CH-1:0]            init_lvl, cmp_wr, stat_clr;
  logic [N_CH-1:0][CNT_W-1:0] cmp;
  logic [N_CH-1:0]            pins, hits, flags;

  oc_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_o(run), .sel_o(sel), .ctrl_wr_o(ctrl_wr), .cfg_o(cfg), .cfg_wr_o(cfg_wr),
    .init_lvl_o(init_lvl), .cmp_o(cmp), .cmp_wr_o(cmp_wr), .stat_clr_o(stat_clr)
  );

  oc_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .sel(sel), .restart(ctrl_wr), .tick_o(tick)
  );

  oc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt_o(count_o)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    oc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .cnt(count_o), .cmp(cmp[ch]),
      .cmp_wr(cmp_wr[ch]), .cfg(cfg[ch]), .cfg_load(cfg_wr), .load_lvl(init_lvl[ch]),
      .stat_clr(stat_clr[ch]), .pin_o(pins[ch]), .hit_o(hits[ch]), .flag_o(flags[ch])
    );
  end

  assign pin_a  = pins[0];
  assign pin_b  = pins[1];
  assign hit_a  = hits[0];
  assign hit_b  = hits[1];
  assign flag_a = flags[0];
  assign flag_b = flags[1];

  // R1: one cycle after reset every output is cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (count_o == '0 && pins == '0 && hits == '0 && flags == '0));

endmodule

// File: tb/sim_oc_timer.sv
module sim_oc_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        pin_a, pin_b, hit_a, hit_b, flag_a, flag_b;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  oc_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .pin_a(pin_a), .pin_b(pin_b), .hit_a(hit_a), .hit_b(hit_b),
    .flag_a(flag_a), .flag_b(flag_b)
  );

  // reference state built from the requirements
  logic [15:0] m_cnt;
  logic        m_run;
  logic [1:0]  m_sel;
  logic [2:0]  m_pre;
  logic [1:0]  m_act [2];
  logic        m_init[2];
  logic [15:0] m_cmp [2];
  logic        m_arm [2];
  logic        m_pin [2];
  logic        m_hit [2];
  logic        m_flag[2];

  function automatic logic div_tick(logic run, logic [1:0] sel, logic [2:0] pre);
    logic [2:0] mask;
    mask = 3'((4'd1 << sel) - 4'd1);
    return run && ((pre & mask) == mask);
  endfunction

  function automatic logic act_result(logic [1:0] act, logic cur);
    case (act)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic model_step(input logic r, input logic w, input logic [2:0] a, input logic [15:0] d);
    logic tk;
    logic hit[2];
    if (r) begin
      m_cnt = '0; m_run = 0; m_sel = '0; m_pre = '0;
      for (int c = 0; c < 2; c++) begin
        m_act[c] = '0; m_init[c] = 0; m_cmp[c] = '0; m_arm[c] = 1;
        m_pin[c] = 0; m_hit[c] = 0; m_flag[c] = 0;
      end
      return;
    end
    tk = div_tick(m_run, m_sel, m_pre);
    for (int c = 0; c < 2; c++) hit[c] = tk && m_arm[c] && (m_cnt == m_cmp[c]);
    for (int c = 0; c < 2; c++) begin
      m_hit[c] = hit[c];
      if (w && a == 3'd1) m_pin[c] = d[3*c + 2];
      else if (hit[c]) m_pin[c] = act_result(m_act[c], m_pin[c]);
      if (hit[c]) m_flag[c] = 1;
      else if (w && a == 3'd4 && d[c]) m_flag[c] = 0;
      if (w && a == 3'(2 + c)) m_arm[c] = 0;
      else if (tk) m_arm[c] = 1;
      if (w && a == 3'(2 + c)) m_cmp[c] = d;
      if (w && a == 3'd1) begin
        m_act[c] = d[3*c +: 2];
        m_init[c] = d[3*c + 2];
      end
    end
    if (tk) m_cnt = m_cnt + 16'd1;
    if (w && a == 3'd0) m_pre = '0;
    else if (m_run) m_pre = m_pre + 3'd1;
    else m_pre = '0;
    if (w && a == 3'd0) begin
      m_run = d[0];
      m_sel = d[2:1];
    end
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2", "count", 32'(count_o), 32'(m_cnt));
    check("R7", "pin_a", 32'(pin_a), 32'(m_pin[0]));
    check("R7", "pin_b", 32'(pin_b), 32'(m_pin[1]));
    check("R5", "hit_a", 32'(hit_a), 32'(m_hit[0]));
    check("R5", "hit_b", 32'(hit_b), 32'(m_hit[1]));
    check("R10", "flag_a", 32'(flag_a), 32'(m_flag[0]));
    check("R10", "flag_b", 32'(flag_b), 32'(m_flag[1]));
  endtask

  task automatic step();
    logic r, w;
    logic [2:0] a;
    logic [15:0] d;
    r = rst; w = wr_en; a = wr_addr; d = wr_data;
    @(posedge clk);
    model_step(r, w, a, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1;
    idle(2);
    rst = 0;
  endtask

  initial begin
    #1900000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    int hits, guard;
    int seed;
    seed = $urandom(32'hC0DE);
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1", "count after reset", 32'(count_o), 0);
    check("R1", "pins after reset", {30'd0, pin_b, pin_a}, 0);
    check("R1", "flags after reset", {30'd0, flag_b, flag_a}, 0);

    // R2 no counting while stopped
    idle(10);
    check("R2", "count while stopped", 32'(count_o), 0);

    // R8 config load: A toggle init 1, B drive-high init 0
    wr(3'd1, 16'd23);
    check("R8", "pin_a init level", 32'(pin_a), 1);
    check("R11", "pin_b init level", 32'(pin_b), 0);

    // R5 match timing, div1
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'd1);
    guard = 0;
    while (count_o != 16'd4 && guard < 50) begin step(); guard++; end
    check("R5", "hit_a as count leaves 3", 32'(hit_a), 1);
    check("R5", "pin_a toggled on step", 32'(pin_a), 0);
    check("R11", "pin_b untouched by A", 32'(pin_b), 0);

    // R3 divider phase after control write (div4)
    wr(3'd0, 16'd5);
    c0 = count_o;
    idle(3);
    check("R3", "no step before 4 cycles", 32'(count_o), 32'(c0));
    idle(1);
    check("R3", "step at 4th cycle", 32'(count_o), 32'(c0 + 16'd1));

    // R6 single pulse over a long state (div8)
    wr(3'd0, 16'd7);
    wr(3'd2, count_o + 16'd1);
    hits = 0;
    for (int i = 0; i < 40; i++) begin step(); if (hit_a) hits++; end
    check("R6", "hits during one long state", 32'(hits), 1);

    // R9 write equal to current count is suppressed in this state
    guard = 0;
    c0 = count_o;
    while (count_o == c0 && guard < 20) begin step(); guard++; end
    wr(3'd2, count_o);
    c0 = 16'(pin_a);
    hits = 0;
    for (int i = 0; i < 10; i++) begin step(); if (hit_a) hits++; end
    check("R9", "no hit for value written equal", 32'(hits), 0);
    check("R9", "pin_a unchanged", 32'(pin_a), 32'(c0[0]));

    // R10 W1C of flag A, flag B kept
    wr(3'd4, 16'd1);
    check("R10", "flag_a cleared", 32'(flag_a), 0);

    // R4 wrap with div1
    do_reset();
    wr(3'd1, 16'd24);
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'd1);
    guard = 0;
    while (count_o != 16'hFFFF && guard < 70000) begin step(); guard++; end
    step();
    check("R4", "count wrapped", 32'(count_o), 0);
    check("R4", "hit_a for 0xFFFF", 32'(hit_a), 1);
    check("R4", "no hit_b at wrap", 32'(hit_b), 0);
    step();
    check("R4", "hit_b after state 0", 32'(hit_b), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(11) == 0) begin
        logic [2:0] a;
        logic [15:0] d;
        a = 3'($urandom_range(7));
        d = 16'($urandom);
        if (a == 3'd2 || a == 3'd3) d = count_o + 16'($urandom_range(5));
        if (a == 3'd0) d = {13'd0, 2'($urandom_range(3)), ($urandom_range(7) != 0)};
        wr(a, d);
      end else begin
        step();
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule